// File: doc/BRIEF.md
# Vertical Sync Generator with Soft Lock

This block makes the vertical sync output of a display back end. It does not count pixel clocks. It counts lines, advancing once on each line-start strobe from the horizontal generator. A field phase counter runs from 0 to one less than the programmed number of lines per field. The output is asserted for two lines at phase 0 and for two lines at half the field. This gives two output pulses per field, at double the field rate.

In freerunning mode the counter wraps on its own and ignores the incoming vertical sync. In locked mode the field start is placed a programmable number of lines after each incoming vertical sync strobe. The move into lock is soft. While aligning, the generator keeps running freely and nudges its phase by one line per field, by holding or skipping one count. The nudge is applied only when the measured incoming field length equals the programmed one, and it stops once the phase error is zero. A filtered signal-present flag can force vertical freerun, horizontal freerun, or both, each with its own enable.

All inputs are plain control levels or single-cycle strobes. There is no data stream, so no valid/ready handshake and no back-pressure. Both strobes are sampled only on clock edges where the line strobe is high. The incoming vertical strobe must coincide with a line strobe.

Top module: `vsync_softlock_gen`

## Requirements
- R1: In freerun (`free_mode`=1), after the k-th line strobe since reset the field phase is k mod L, where L is `lines_per_field` (L >= 4). The un-inverted output is high exactly when the phase is 0, 1, L/2 or L/2+1, with L/2 rounded down. This gives two pulses per field, each two lines long.
- R2: `out_pol_inv`=1 inverts `vsync_out` combinationally. `out_pol_inv`=0 leaves it as is.
- R3: In freerun the strobes on `vsync_in` have no effect on `vsync_out`.
- R4: Once locked, each field starts (phase 0) on the line strobe that comes `delay_lines` lines after an incoming vertical strobe. With a delay of 0 it starts on that same strobe.
- R5: While aligning, each half-field interval between output rising edges departs from nominal by at most one line. If the error e (phase reached at the target line) satisfies e <= L/2, the field is lengthened by holding the count for one line. Otherwise one count is skipped.
- R6: An alignment step, and the transition to lock, happen only when the last measured distance between incoming strobes equals L. Otherwise the phase keeps freerunning.
- R7: `locked` goes high at the target line where the phase error is zero. It stays high until freerun is selected or forced.
- R8: `sig_present` is judged only at field starts, and a change is taken only after 3 consecutive field starts that disagree with the filtered state. After reset the filtered state is "present".
- R9: When the filtered signal is absent, `auto_v_en` forces vertical freerun, so `locked` drops on the next line strobe, and `auto_h_en` drives `h_free_force` high. With both enables low the loss has no effect.
- R10: During and right after reset, `vsync_out` equals `out_pol_inv`, and `locked` and `h_free_force` are low.
- R11: `vsync_out` (polarity held fixed) changes only on clock edges where `line_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_stb | input | 1 | One-cycle strobe at every line start |
| vsync_in | input | 1 | Incoming vertical sync strobe, valid with line_stb |
| free_mode | input | 1 | 1 = freerun, 0 = follow vsync_in |
| lines_per_field | input | LINE_W | Lines per field L |
| delay_lines | input | LINE_W | Lines from incoming sync to field start, below L |
| out_pol_inv | input | 1 | Output polarity inversion |
| auto_h_en | input | 1 | Allow horizontal freerun on signal loss |
| auto_v_en | input | 1 | Allow vertical freerun on signal loss |
| sig_present | input | 1 | Raw input-signal-present flag |
| vsync_out | output | 1 | Vertical sync output |
| h_free_force | output | 1 | Request for horizontal freerun |
| locked | output | 1 | Phase aligned to the incoming sync |

## Verification
The freerun table uses odd and even field lengths, both polarities, and incoming strobes at unrelated offsets. It compares every line against the phase formula, which separates wrap, pulse-placement and polarity errors from leaks of the incoming sync.

Two locked runs start with phase errors on opposite sides of half a field. They show that the pull direction is chosen correctly, that no half-field moves by more than one line, and that the final position honours the delay. A run with incoming strobes one line too far apart must never lock or nudge.

The signal-loss runs first use both enables off and then both on. They count field starts, so that an off-by-one in the filter length or a missing enable gate shows up.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_LOCK  = 2'd2
  } vsg_state_e;
endpackage

// File: rtl/vsg_sig_filter.sv
module vsg_sig_filter #(
  parameter int FILT_FIELDS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic field_stb,
  input  logic sig_present,
  output logic sig_ok
);
  localparam int CW = $clog2(FILT_FIELDS + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_FIELDS - 1);

  logic [CW-1:0] agree_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_ok    <= 1'b1;
      agree_cnt <= '0;
    end else if (field_stb) begin
      if (sig_present != sig_ok) begin
        if (agree_cnt == LAST) begin
          sig_ok    <= sig_present;
          agree_cnt <= '0;
        end else begin
          agree_cnt <= agree_cnt + 1'b1;
        end
      end else begin
        agree_cnt <= '0;
      end
    end
  end

  // R8: the filtered state only moves at a field start
  p_flip_at_field_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_ok != $past(sig_ok)) |-> $past(field_stb));
endmodule

// File: rtl/vsg_in_meter.sv
module vsg_in_meter #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic              vsync_in,
  input  logic [LINE_W-1:0] lpf,
  input  logic [LINE_W-1:0] dly,
  output logic              match,
  output logic              tgt
);
  localparam logic [LINE_W-1:0] CNT_MAX = '1;

  logic [LINE_W-1:0] in_cnt;
  logic [LINE_W-1:0] dcnt;
  logic              seen;
  logic              pend;
  logic [LINE_W:0]   meas;

  assign meas = {1'b0, in_cnt} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt <= '0;
      seen   <= 1'b0;
      match  <= 1'b0;
    end else if (line_stb) begin
      if (vsync_in) begin
        in_cnt <= '0;
        seen   <= 1'b1;
        match  <= seen && (meas == {1'b0, lpf});
      end else if (in_cnt != CNT_MAX) begin
        in_cnt <= in_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
      pend <= 1'b0;
    end else if (line_stb) begin
      if (vsync_in) begin
        dcnt <= dly;
        pend <= (dly != '0);
      end else if (pend) begin
        dcnt <= dcnt - 1'b1;
        if (dcnt == LINE_W'(1)) pend <= 1'b0;
      end
    end
  end

  assign tgt = line_stb &&
               ((vsync_in && dly == '0) ||
                (!vsync_in && pend && dcnt == LINE_W'(1)));

  // R6: a length match is only ever declared on an incoming strobe
  p_match_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match) |-> $past(line_stb && vsync_in));
endmodule

// File: rtl/vsg_phase_ctl.sv
module vsg_phase_ctl
  import vsg_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic [LINE_W-1:0] lpf,
  input  logic              force_free,
  input  logic              tgt,
  input  logic              match,
  output logic [LINE_W-1:0] ph_next,
  output logic              locked
);
  vsg_state_e        st, st_next;
  logic [LINE_W-1:0] ph, ph_inc, ph_skip, half;

  assign half    = lpf >> 1;
  assign ph_inc  = (ph >= lpf - 1'b1) ? '0 : ph + 1'b1;
  assign ph_skip = (ph_inc >= lpf - 1'b1) ? '0 : ph_inc + 1'b1;

  always_comb begin
    ph_next = ph;
    st_next = st;
    if (line_stb) begin
      ph_next = ph_inc;
      unique case (st)
        ST_FREE: begin
          if (!force_free) st_next = ST_ALIGN;
        end
        ST_ALIGN: begin
          if (force_free) begin
            st_next = ST_FREE;
          end else if (tgt && match) begin
            if (ph_inc == '0)        st_next = ST_LOCK;
            else if (ph_inc <= half) ph_next = ph;
            else                     ph_next = ph_skip;
          end
        end
        ST_LOCK: begin
          if (force_free) st_next = ST_FREE;
          else if (tgt)   ph_next = '0;
        end
        default: st_next = ST_FREE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
      st <= ST_FREE;
    end else begin
      ph <= ph_next;
      st <= st_next;
    end
  end

  assign locked = (st == ST_LOCK);

  // R7: lock is entered only with the phase sitting at zero
  p_lock_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (ph == '0));
  // R5: an aligning line moves the phase by 0, 1 or 2 counts
  p_align_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && st == ST_ALIGN && !force_free) |=>
      (ph == $past(ph_inc) || ph == $past(ph) || ph == $past(ph_skip)));
  // R9: forced freerun clears lock on the same line
  p_force_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && force_free) |=> !locked);
endmodule

// File: rtl/vsg_pulse_gen.sv
module vsg_pulse_gen #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic [LINE_W-1:0] lpf,
  input  logic [LINE_W-1:0] ph_next,
  output logic              vs_act
);
  logic [LINE_W-1:0] half;
  logic              act_n;

  assign half  = lpf >> 1;
  assign act_n = (ph_next == '0) || (ph_next == LINE_W'(1)) ||
                 (ph_next == half) || (ph_next == half + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vs_act <= 1'b0;
    else if (line_stb) vs_act <= act_n;
  end

  // R11: the pulse level is held between line strobes
  p_hold_between_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(vs_act));
endmodule

// File: rtl/vsync_softlock_gen.sv
module vsync_softlock_gen #(
  parameter int LINE_W      = 11,
  parameter int FILT_FIELDS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic              vsync_in,
  input  logic              free_mode,
  input  logic [LINE_W-1:0] lines_per_field,
  input  logic [LINE_W-1:0] delay_lines,
  input  logic              out_pol_inv,
  input  logic              auto_h_en,
  input  logic              auto_v_en,
  input  logic              sig_present,
  output logic              vsync_out,
  output logic              h_free_force,
  output logic              locked
);
  logic              sig_ok, match, tgt, force_free, field_stb, vs_act;
  logic [LINE_W-1:0] ph_next;

  assign force_free   = free_mode | (auto_v_en & ~sig_ok);
  assign h_free_force = auto_h_en & ~sig_ok;
  assign field_stb    = line_stb && (ph_next == '0);
  assign vsync_out    = vs_act ^ out_pol_inv;

  vsg_in_meter #(.LINE_W(LINE_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vsync_in(vsync_in),
    .lpf(lines_per_field), .dly(delay_lines), .match(match), .tgt(tgt));

  vsg_phase_ctl #(.LINE_W(LINE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .lpf(lines_per_field),
    .force_free(force_free), .tgt(tgt), .match(match),
    .ph_next(ph_next), .locked(locked));

  vsg_pulse_gen #(.LINE_W(LINE_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .lpf(lines_per_field),
    .ph_next(ph_next), .vs_act(vs_act));

  vsg_sig_filter #(.FILT_FIELDS(FILT_FIELDS)) u_filt (
    .clk(clk), .rst_n(rst_n), .field_stb(field_stb),
    .sig_present(sig_present), .sig_ok(sig_ok));
endmodule

// File: tb/vsync_softlock_gen_tb.sv
module vsync_softlock_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 11;
  localparam int unsigned FR_TAB [4][3] = '{
    '{10, 0, 3}, '{11, 1, 0}, '{7, 0, 5}, '{16, 1, 9}};

  logic clk = 1'b0, rst_n = 1'b0, line_stb = 1'b0, vsync_in = 1'b0;
  logic free_mode = 1'b1, out_pol_inv = 1'b0, auto_h_en = 1'b0;
  logic auto_v_en = 1'b0, sig_present = 1'b1;
  logic [LW-1:0] lines_per_field = LW'(10), delay_lines = '0;
  logic vsync_out, h_free_force, locked;

  int n_chk = 0, n_bad = 0, gl = 0;
  int last_rise = -1, min_iv = 1000, max_iv = 0;
  bit prev_act = 0, ever_locked = 0;

  vsync_softlock_gen #(.LINE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vsync_in(vsync_in),
    .free_mode(free_mode), .lines_per_field(lines_per_field),
    .delay_lines(delay_lines), .out_pol_inv(out_pol_inv),
    .auto_h_en(auto_h_en), .auto_v_en(auto_v_en), .sig_present(sig_present),
    .vsync_out(vsync_out), .h_free_force(h_free_force), .locked(locked));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_iv();
    min_iv = 1000; max_iv = 0; last_rise = -1; ever_locked = 0;
  endtask

  task automatic line_step(bit vin);
    bit a;
    @(negedge clk);
    line_stb = 1'b1; vsync_in = vin;
    @(negedge clk);
    line_stb = 1'b0; vsync_in = 1'b0;
    gl++;
    a = vsync_out ^ out_pol_inv;
    if (a && !prev_act) begin
      if (last_rise >= 0) begin
        if (gl - last_rise < min_iv) min_iv = gl - last_rise;
        if (gl - last_rise > max_iv) max_iv = gl - last_rise;
      end
      last_rise = gl;
    end
    prev_act = a;
    if (locked) ever_locked = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run(int n, int per, int off);
    for (int i = 0; i < n; i++) line_step(((gl + 1) % per) == off);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; line_stb = 1'b0; vsync_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    gl = 0; prev_act = 0;
    clear_iv();
  endtask

  function automatic int exp_act(int ph, int lpf);
    int h = lpf / 2;
    return (ph == 0 || ph == 1 || ph == h || ph == h + 1) ? 1 : 0;
  endfunction

  initial begin
    // R10: reset state
    rst_n = 1'b0; out_pol_inv = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 vsync_out in reset", vsync_out, 0);
    chk("R10 locked in reset", locked, 0);
    chk("R10 h_free_force in reset", h_free_force, 0);
    out_pol_inv = 1'b1;
    @(negedge clk);
    chk("R2/R10 inverted idle level", vsync_out, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", vsync_out, 1);

    // R1 R2 R3: freerun table, vsync_in strobes applied and ignored
    for (int v = 0; v < 4; v++) begin
      free_mode = 1'b1;
      lines_per_field = LW'(FR_TAB[v][0]);
      out_pol_inv = FR_TAB[v][1][0];
      delay_lines = '0;
      do_reset();
      for (int k = 1; k <= 2 * int'(FR_TAB[v][0]); k++) begin
        line_step(((gl + 1) % int'(FR_TAB[v][0])) == int'(FR_TAB[v][2]));
        chk("R1/R2/R3 freerun line", vsync_out,
            exp_act(k % int'(FR_TAB[v][0]), int'(FR_TAB[v][0])) ^ int'(FR_TAB[v][1]));
      end
      chk("R1 locked stays low in freerun", locked, 0);
    end

    // R5 R7 R4: lengthening pull, delay 3, incoming at line%10==2
    free_mode = 1'b0; out_pol_inv = 1'b0;
    lines_per_field = LW'(10); delay_lines = LW'(3);
    do_reset();
    run(3, 10, 2);
    clear_iv();
    run(117, 10, 2);
    chk("R7 lock reached (lengthen)", locked, 1);
    chk("R5 shortest half-field (lengthen)", min_iv, 5);
    chk("R5 longest half-field (lengthen)", max_iv, 6);
    for (int i = 0; i < 20; i++) begin
      int m;
      run(1, 10, 2);
      m = gl % 10;
      chk("R4 locked position delay 3", vsync_out,
          (m == 5 || m == 6 || m == 0 || m == 1) ? 1 : 0);
    end

    // R9 negative: loss with both enables off has no effect
    sig_present = 1'b0;
    run(40, 10, 2);
    chk("R9 no force when disabled", h_free_force, 0);
    chk("R9 lock kept when disabled", locked, 1);
    sig_present = 1'b1;
    run(40, 10, 2);

    // R8 R9: filtered loss with enables on
    auto_h_en = 1'b1; auto_v_en = 1'b1;
    while ((gl % 10) != 5) run(1, 10, 2);
    sig_present = 1'b0;
    begin
      int fs = 0;
      while (fs < 3) begin
        run(1, 10, 2);
        if ((gl % 10) == 5) begin
          fs++;
          if (fs == 2) begin
            chk("R8 no switch after two fields", h_free_force, 0);
            chk("R8 still locked after two fields", locked, 1);
          end
        end
      end
    end
    chk("R8/R9 h force after three fields", h_free_force, 1);
    run(1, 10, 2);
    chk("R9 vertical freerun drops lock", locked, 0);
    sig_present = 1'b1; auto_h_en = 1'b0; auto_v_en = 1'b0;

    // R5 R7 R4: shortening pull, delay 0, incoming at line%10==7
    delay_lines = '0;
    do_reset();
    run(3, 10, 7);
    clear_iv();
    run(97, 10, 7);
    chk("R7 lock reached (shorten)", locked, 1);
    chk("R5 shortest half-field (shorten)", min_iv, 4);
    chk("R5 longest half-field (shorten)", max_iv, 5);
    for (int i = 0; i < 20; i++) begin
      int m;
      run(1, 10, 7);
      m = gl % 10;
      chk("R4 locked position delay 0", vsync_out,
          (m == 7 || m == 8 || m == 2 || m == 3) ? 1 : 0);
    end

    // R6: incoming field of 11 lines against programmed 10
    delay_lines = LW'(3);
    do_reset();
    run(3, 11, 2);
    clear_iv();
    run(120, 11, 2);
    chk("R6 never locks on length mismatch", ever_locked, 0);
    chk("R6 no nudge, shortest", min_iv, 5);
    chk("R6 no nudge, longest", max_iv, 5);

    summary();
    $finish;
  end
endmodule